// File: doc/BRIEF.md
# Ternary Gate Cell with Cycle Delay

This cell evaluates one logic gate (inverter, conjunction or disjunction) over a small set of input lanes. Each lane carries a three-state value: zero, one or unknown. Unknown propagates under dominance rules. A zero on any active input forces a conjunction to zero. A one on any active input forces a disjunction to one. Otherwise unknown wins over the remaining known values.

The result appears on the output a selectable number of clock cycles after the inputs that produced it. The delay runs from 0 to 7, and 0 gives a direct combinational path. The delay is built as a shift pipeline of ternary values, so the output holds steady while the inputs do not change. After reset every stage reads as unknown.

An enable mask per lane lets a cell instanced for four lanes act as a narrower gate. Cells like this one can be chained to model a timed gate network cycle by cycle.

Top module: `tern_gate_cell`

## Requirements
- R1: Values are encoded as zero = 2'b00, one = 2'b01 and unknown = 2'b10. The output never shows 2'b11.
- R2: When the gate kind is 2'b00 (inverter), the gate takes lane 0 only, whatever the mask says. One becomes zero, zero becomes one, and unknown stays unknown.
- R3: When the gate kind is 2'b01 (conjunction), the result is zero if any enabled lane is zero. It is one if all enabled lanes are one. Otherwise it is unknown.
- R4: When the gate kind is 2'b10 (disjunction), the result is one if any enabled lane is one. It is zero if all enabled lanes are zero. Otherwise it is unknown.
- R5: A lane whose mask bit (bit i for lane i, which sits on input bits 2i+1:2i) is 0 has no effect on the result. With no lane enabled, conjunction gives one and disjunction gives zero.
- R6: An input code of 2'b11 on an enabled lane is read as unknown.
- R7: With a delay setting d from 1 to 7, the output during a cycle equals the gate result of the inputs present at the clock edge d edges earlier.
- R8: With a delay setting of 0, the output follows the gate result of the current inputs with no register in the path.
- R9: Synchronous active-high reset fills every delay stage with unknown. For d >= 1, the output reads unknown until d edges after reset have been taken.
- R10: Gate kind 2'b11 produces unknown.
- R11: While the inputs and the delay setting stay constant, the output stays constant once d edges have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| kind | input | 2 | Gate kind: 00 inverter, 01 conjunction, 10 disjunction, 11 unknown |
| dly | input | 3 | Delay in clock cycles, 0 to 7 |
| lane_en | input | 4 | Per-lane enable mask |
| din | input | 8 | Four ternary lanes, lane i on bits 2i+1:2i |
| result | output | 2 | Ternary gate result after the selected delay |

## Verification
The hardest situation to reach from the ports is a change of the delay tap while the pipeline holds a mixed history of values, including unknowns left over from a reset. To reach it, the stimulus changes the delay setting on every cycle while it sweeps every gate kind, every mask and every lane code. A mid-run reset is also issued while results are still in flight. The bench keeps its own history of expected gate results, so each sampled output is checked against the stage the selected delay addresses.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef enum logic [1:0] {
        TV_ZERO = 2'b00,
        TV_ONE  = 2'b01,
        TV_UNK  = 2'b10
    } tern_t;

    typedef enum logic [1:0] {
        GK_INV = 2'b00,
        GK_AND = 2'b01,
        GK_OR  = 2'b10,
        GK_BAD = 2'b11
    } gate_kind_t;

    // Map a raw two-bit code onto a legal ternary value (11 -> unknown).
    function automatic tern_t tern_norm(input logic [1:0] code);
        case (code)
            2'b00:   return TV_ZERO;
            2'b01:   return TV_ONE;
            default: return TV_UNK;
        endcase
    endfunction

    function automatic tern_t tern_inv(input tern_t v);
        case (v)
            TV_ZERO: return TV_ONE;
            TV_ONE:  return TV_ZERO;
            default: return TV_UNK;
        endcase
    endfunction

endpackage

// File: rtl/tern_eval.sv
module tern_eval
    import tern_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]         kind,
    input  logic [LANES-1:0]   lane_en,
    input  logic [2*LANES-1:0] din,
    output tern_t              value
);

    logic [LANES-1:0] has_zero;
    logic [LANES-1:0] has_one;
    logic [LANES-1:0] has_unk;

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            tern_t lv;
            assign lv          = tern_norm(din[2*i +: 2]);
            assign has_zero[i] = lane_en[i] && (lv == TV_ZERO);
            assign has_one[i]  = lane_en[i] && (lv == TV_ONE);
            assign has_unk[i]  = lane_en[i] && (lv == TV_UNK);
        end
    endgenerate

    tern_t and_v;
    tern_t or_v;
    tern_t inv_v;

    always_comb begin
        if (|has_zero)     and_v = TV_ZERO;
        else if (|has_unk) and_v = TV_UNK;
        else               and_v = TV_ONE;

        if (|has_one)      or_v = TV_ONE;
        else if (|has_unk) or_v = TV_UNK;
        else               or_v = TV_ZERO;

        inv_v = tern_inv(tern_norm(din[1:0]));
    end

    always_comb begin
        case (gate_kind_t'(kind))
            GK_INV:  value = inv_v;
            GK_AND:  value = and_v;
            GK_OR:   value = or_v;
            default: value = TV_UNK;
        endcase
    end

endmodule

// File: rtl/tern_delay_line.sv
module tern_delay_line
    import tern_pkg::*;
#(
    parameter int DEPTH = 7,
    parameter int SELW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  tern_t           d_in,
    input  logic [SELW-1:0] sel,
    output tern_t           q_out
);

    tern_t stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= TV_UNK;
        else     stg[0] <= d_in;
    end

    genvar s;
    generate
        for (s = 1; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= TV_UNK;
                else     stg[s] <= stg[s-1];
            end
        end
    endgenerate

    // Tap select: sel 0 bypasses the pipeline, sel k reads stage k-1.
    tern_t tap;
    always_comb begin
        tap = TV_UNK;
        for (int k = 1; k <= DEPTH; k++) begin
            if (int'(sel) == k) tap = stg[k-1];
        end
        q_out = (sel == '0) ? d_in : tap;
    end

endmodule

// File: rtl/tern_gate_cell.sv
module tern_gate_cell
    import tern_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int MAX_DLY = 7,
    localparam int DW     = $clog2(MAX_DLY + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         kind,
    input  logic [DW-1:0]      dly,
    input  logic [LANES-1:0]   lane_en,
    input  logic [2*LANES-1:0] din,
    output logic [1:0]         result
);

    tern_t eval_val;
    tern_t dl_out;

    tern_eval #(.LANES(LANES)) u_eval (
        .kind    (kind),
        .lane_en (lane_en),
        .din     (din),
        .value   (eval_val)
    );

    tern_delay_line #(.DEPTH(MAX_DLY), .SELW(DW)) u_dline (
        .clk   (clk),
        .rst   (rst),
        .d_in  (eval_val),
        .sel   (dly),
        .q_out (dl_out)
    );

    assign result = dl_out;

endmodule

// File: rtl/tern_gate_cell_chk.sv
module tern_gate_cell_chk
    import tern_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW    = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         kind,
    input logic [DW-1:0]      dly,
    input logic [LANES-1:0]   lane_en,
    input logic [2*LANES-1:0] din,
    input logic [1:0]         result,
    input tern_t              eval_val
);

    logic any_zero, any_one;
    always_comb begin
        any_zero = 1'b0;
        any_one  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_en[i] && din[2*i +: 2] == 2'b00) any_zero = 1'b1;
            if (lane_en[i] && din[2*i +: 2] == 2'b01) any_one  = 1'b1;
        end
    end

    // R1
    a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
        result != 2'b11);

    // R2
    a_r2_inv_one: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b00 && dly == '0 && din[1:0] == 2'b01) |-> result == 2'b00);

    // R3
    a_r3_and_zero: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b01 && dly == '0 && any_zero) |-> result == 2'b00);

    // R4
    a_r4_or_one: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b10 && dly == '0 && any_one) |-> result == 2'b01);

    // R7
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (dly == 3'(1) && !$past(rst)) |-> result == $past(eval_val));

    // R9
    a_r9_reset_unknown: assert property (@(posedge clk)
        rst |=> (dly == '0 || result == 2'b10));

endmodule

bind tern_gate_cell tern_gate_cell_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .dly      (dly),
    .lane_en  (lane_en),
    .din      (din),
    .result   (result),
    .eval_val (eval_val)
);

// File: tb/tern_gate_cell_test.sv
module tern_gate_cell_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] kind = 2'b00;
    logic [2:0] dly = 3'd0;
    logic [3:0] lane_en = 4'hF;
    logic [7:0] din = 8'h00;
    logic [1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int since_rst = 0;
    bit edge_seen = 1'b0;
    logic [1:0] hist [7];

    always #(PERIOD/2) clk = ~clk;

    tern_gate_cell uut (
        .clk(clk), .rst(rst), .kind(kind), .dly(dly),
        .lane_en(lane_en), .din(din), .result(result)
    );

    // Reference gate result computed from the requirements.
    function automatic logic [1:0] ref_gate(input logic [1:0] k, input logic [3:0] e,
                                            input logic [7:0] x);
        int zeros = 0, ones = 0, unks = 0;
        logic [1:0] c0;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] c = x[2*i +: 2];
            if (e[i]) begin
                if (c == 2'b00) zeros++;
                else if (c == 2'b01) ones++;
                else unks++;          // R6: 11 counts as unknown
            end
        end
        c0 = x[1:0];
        case (k)
            2'b00: return (c0 == 2'b00) ? 2'b01 : (c0 == 2'b01) ? 2'b00 : 2'b10;
            2'b01: return (zeros > 0) ? 2'b00 : (unks > 0) ? 2'b10 : 2'b01;
            2'b10: return (ones > 0) ? 2'b01 : (unks > 0) ? 2'b10 : 2'b00;
            default: return 2'b10;    // R10
        endcase
    endfunction

    function automatic string kind_tag(input logic [1:0] k, input logic [3:0] e,
                                       input logic [7:0] x);
        string t;
        case (k)
            2'b00: t = "R2";
            2'b01: t = "R3";
            2'b10: t = "R4";
            default: t = "R10";
        endcase
        if (k != 2'b00 && e != 4'hF) t = {t, "/R5"};
        for (int i = 0; i < 4; i++)
            if (e[i] && x[2*i +: 2] == 2'b11) t = {t, "/R6"};
        return t;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result=%b expected=%b (kind=%b dly=%0d en=%b din=%b)",
                     tag, act, exp, kind, dly, lane_en, din);
        end
    endtask

    // Apply inputs, check at the falling edge, then take a rising edge.
    task automatic step(input logic [1:0] k, input logic [2:0] d,
                        input logic [3:0] e, input logic [7:0] x);
        logic [1:0] exp;
        string dtag;
        kind = k; dly = d; lane_en = e; din = x;
        @(negedge clk);
        if (edge_seen) begin
            if (d == 3'd0) begin
                exp = ref_gate(k, e, x);
                dtag = "R1/R8";
            end else begin
                exp = hist[d-1];
                dtag = (rst || since_rst < int'(d)) ? "R1/R9" : "R1/R7";
            end
            check({dtag, "/", kind_tag(k, e, x)}, result, exp);
        end
        @(posedge clk);
        edge_seen = 1'b1;
        if (rst) begin
            for (int i = 0; i < 7; i++) hist[i] = 2'b10;
            since_rst = 0;
        end else begin
            for (int i = 6; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = ref_gate(k, e, x);
            since_rst++;
        end
        #1;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
    end

    initial begin
        logic [1:0] held;
        // R9: reset state
        for (int i = 0; i < 3; i++) step(2'b01, 3'd4, 4'hF, 8'h55);
        rst = 1'b0;
        // R9: output unknown until the pipeline refills (dly 7, ones driven)
        for (int i = 0; i < 9; i++) step(2'b01, 3'd7, 4'hF, 8'h55);

        // R2..R8, R10: sweep kinds, masks and lane codes with a moving tap
        for (int k = 0; k < 4; k++)
            for (int e = 0; e < 16; e++)
                for (int x = 0; x < 256; x++)
                    step(2'(k), 3'((x + e + k) % 8), 4'(e), 8'(x));

        // R9: reset in the middle of a run with results in flight
        rst = 1'b1;
        step(2'b10, 3'd5, 4'hF, 8'h01);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) step(2'b10, 3'd5, 4'hF, 8'h01);

        // R11: constant inputs give a constant output after the delay
        for (int i = 0; i < 8; i++) step(2'b00, 3'd7, 4'h1, 8'h00);
        @(negedge clk);
        held = result;
        check("R11 settled", held, 2'b01);
        for (int i = 0; i < 10; i++) begin
            step(2'b00, 3'd7, 4'h1, 8'h00);
            check("R11 hold", result, held);
        end

        summary();
    end

endmodule